// File: doc/BRIEF.md
# Host-Slave Data Bus Buffer

This block sits between a master processor's asynchronous peripheral bus and a slave controller running on its own clock. The master sees a chip select, separate read and write strobes (all active low), one address bit and an 8-bit data bus. It can write a byte into an input register, read a byte from an output register, or read an 8-bit status word. The two directions use separate registers, so traffic in one direction never destroys a byte waiting in the other.

The slave side is synchronous to `clk`. Bytes written by the master leave the block on a valid/ready stream. Bytes for the master enter on a second valid/ready stream. Plain control pins let the slave load the four user bits of the status word and set or clear flag F0.

The master strobes pass through a two-flop synchronizer, and every flag change is taken from the trailing edge of a synchronized strobe. While the master is reading the status word, the slave cannot change that word. A status or F0 request made during that window is held and applied once the read ends. Both streams stall during the window.

Stream rules:
- `in_valid` does not depend on `in_ready`.
- A byte is taken when both `in_valid` and `in_ready` are high at a clock edge.
- `out_data` is taken when `out_valid` and `out_ready` are both high at an edge.
- The slave keeps `out_valid` and `out_data` steady until that transfer happens.

Top module: `hsb_bridge`

## Requirements
- R1: `rst_in` passes through two flip-flops to form `sync_rst`. While `sync_rst` is high, and after it falls, the status word and both data registers are all zero until the next event. `out_ready` is 1 and `in_valid` is 0 after reset.
- R2: The status word has these bits, from bit 7 down to bit 0: user bits U3..U0 in bits 7:4, F1 in bit 3, F0 in bit 2, input-full (IBF) in bit 1 and output-full (OBF) in bit 0. A master read with `host_a0`=1 returns the status word. A read with `host_a0`=0 returns the output register. `host_rdata` is 0 when no selected read is active.
- R3: At the trailing edge of a selected master write, the byte is stored in the input register, IBF becomes 1 and F1 takes the value of `host_a0` (1 for a command, 0 for data). None of these changes while the strobe is still held.
- R4: `in_valid` equals IBF except during the status-read lockout, and `in_data` is the input register. A transfer on the input stream clears IBF.
- R5: `out_ready` is 1 when OBF is 0, except during the lockout. A transfer on the output stream loads the output register and sets OBF.
- R6: The trailing edge of a master read with `host_a0`=0 clears OBF. A read with `host_a0`=1 leaves OBF unchanged.
- R7: A master write leaves the output register unchanged.
- R8: A pulse on `sts_we` copies `sts_data[7:4]` into U3..U0 and leaves status bits 3:0 unchanged.
- R9: A pulse on `f0_set` sets F0 and a pulse on `f0_clr` clears it. If both are high in the same cycle, set wins.
- R10: While the synchronized master read of the status word is active, the status word does not change. A status or F0 request made during that time is applied in the first cycle after the read ends, and the last request wins.
- R11: A strobe with `host_cs_n` high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_in | input | 1 | Raw reset, active high, asynchronous to clk |
| sync_rst | output | 1 | Reset after the two-flop synchronizer |
| host_cs_n | input | 1 | Master chip select, active low |
| host_rd_n | input | 1 | Master read strobe, active low |
| host_wr_n | input | 1 | Master write strobe, active low |
| host_a0 | input | 1 | 1 selects status or command, 0 selects data |
| host_wdata | input | 8 | Byte written by the master |
| host_rdata | output | 8 | Byte returned to the master |
| in_valid | output | 1 | Input register holds a byte for the slave |
| in_ready | input | 1 | Slave accepts the input byte |
| in_data | output | 8 | Input register contents |
| out_valid | input | 1 | Slave offers a byte for the master |
| out_ready | output | 1 | Output register can take a byte |
| out_data | input | 8 | Byte offered by the slave |
| sts_we | input | 1 | Load the user status bits |
| sts_data | input | 8 | Bits 7:4 go to the user status bits |
| f0_set | input | 1 | Set flag F0 |
| f0_clr | input | 1 | Clear flag F0 |

## Verification
The embedded assertions check the following on every cycle:
- The status word holds still while a status read is active.
- IBF and F1 move only in the cycle after a trailing write edge.
- OBF clears after a data read.
- Neither stream transfers into a full register.
- Reset leaves every register at zero.

The bench scenarios are needed for the rest:
- Every byte value travelling through both registers.
- The F1 command/data marking.
- Deferred status and F0 requests applied after the read ends.
- Strobes without chip select being ignored.
- The output register surviving master writes.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  localparam int DW = 8;
  localparam int NIB = DW / 2;

  typedef struct packed {
    logic [NIB-1:0] user;
    logic           f1;
    logic           f0;
    logic           ibf;
    logic           obf;
  } hsb_status_t;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) chain[s] <= chain[s-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hsb_host_if.sv
module hsb_host_if
  import hsb_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          host_cs_n,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic          host_a0,
  input  logic [DW-1:0] host_wdata,
  output logic          rd_fall,
  output logic          wr_fall,
  output logic          cap_a0,
  output logic [DW-1:0] cap_data,
  output logic          lock
);
  localparam int SW = DW + 3;

  logic [SW-1:0] raw, synced;
  logic          rd_s, wr_s, a0_s, rd_q, wr_q;
  logic [DW-1:0] data_s;

  // Data and address travel with the strobes so they stay aligned.
  assign raw = {~host_cs_n & ~host_rd_n, ~host_cs_n & ~host_wr_n, host_a0, host_wdata};

  hsb_sync #(.W(SW), .STAGES(2)) u_sync (.clk(clk), .d(raw), .q(synced));

  assign {rd_s, wr_s, a0_s, data_s} = synced;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      cap_a0   <= 1'b0;
      cap_data <= '0;
    end else begin
      rd_q <= rd_s;
      wr_q <= wr_s;
      if (rd_s | wr_s) cap_a0 <= a0_s;
      if (wr_s) cap_data <= data_s;
    end
  end

  assign rd_fall = rd_q & ~rd_s;
  assign wr_fall = wr_q & ~wr_s;
  assign lock    = rd_s & a0_s;

  p_fall_once_r3: assert property (@(posedge clk) disable iff (rst)
    wr_fall |=> !wr_fall);
endmodule

// File: rtl/hsb_rst_sync.sv
module hsb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_out
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) sr <= {sr[STAGES-2:0], rst_in};

  assign rst_out = sr[STAGES-1];
endmodule

// File: rtl/hsb_regs.sv
module hsb_regs
  import hsb_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_fall,
  input  logic          wr_fall,
  input  logic          cap_a0,
  input  logic [DW-1:0] cap_data,
  input  logic          lock,
  output logic          in_valid,
  input  logic          in_ready,
  output logic [DW-1:0] in_data,
  input  logic          out_valid,
  output logic          out_ready,
  input  logic [DW-1:0] out_data,
  input  logic          sts_we,
  input  logic [DW-1:0] sts_data,
  input  logic          f0_set,
  input  logic          f0_clr,
  output hsb_status_t   status,
  output logic [DW-1:0] obuf
);
  logic [DW-1:0]  ibuf;
  logic           pend_u_v, pend_f0_v, pend_f0;
  logic [NIB-1:0] pend_u;
  logic           in_fire, out_fire;

  assign in_valid  = status.ibf & ~lock;
  assign out_ready = ~status.obf & ~lock;
  assign in_fire   = in_valid & in_ready;
  assign out_fire  = out_valid & out_ready;
  assign in_data   = ibuf;

  always_ff @(posedge clk) begin
    if (rst) begin
      status    <= '0;
      ibuf      <= '0;
      obuf      <= '0;
      pend_u_v  <= 1'b0;
      pend_u    <= '0;
      pend_f0_v <= 1'b0;
      pend_f0   <= 1'b0;
    end else begin
      // Input path: a fresh master byte wins over a concurrent pop.
      if (wr_fall) begin
        ibuf       <= cap_data;
        status.ibf <= 1'b1;
        status.f1  <= cap_a0;
      end else if (in_fire) begin
        status.ibf <= 1'b0;
      end

      // Output path.
      if (out_fire) begin
        obuf       <= out_data;
        status.obf <= 1'b1;
      end else if (rd_fall && !cap_a0) begin
        status.obf <= 1'b0;
      end

      // User bits and F0: deferred while the master reads status.
      if (lock) begin
        if (sts_we) begin
          pend_u_v <= 1'b1;
          pend_u   <= sts_data[DW-1:NIB];
        end
        if (f0_set | f0_clr) begin
          pend_f0_v <= 1'b1;
          pend_f0   <= f0_set;
        end
      end else begin
        pend_u_v  <= 1'b0;
        pend_f0_v <= 1'b0;
        if (sts_we) status.user <= sts_data[DW-1:NIB];
        else if (pend_u_v) status.user <= pend_u;
        if (f0_set | f0_clr) status.f0 <= f0_set;
        else if (pend_f0_v) status.f0 <= pend_f0;
      end
    end
  end

  p_lock_user_r10: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(status.user) && $stable(status.f0));
  p_ibf_set_r3: assert property (@(posedge clk) disable iff (rst)
    wr_fall |=> status.ibf);
  p_f1_trailing_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_fall |=> $stable(status.f1));
  p_ibf_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(status.ibf) |-> $past(wr_fall));
  p_obf_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_fall && !cap_a0 && !out_fire) |=> !status.obf);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    out_fire |-> !status.obf);
  p_pop_full_r4: assert property (@(posedge clk) disable iff (rst)
    in_fire |-> status.ibf);
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (status == '0) && (ibuf == '0) && (obuf == '0));
endmodule

// File: rtl/hsb_bridge.sv
module hsb_bridge
  import hsb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_in,
  output logic          sync_rst,
  input  logic          host_cs_n,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic          host_a0,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          in_valid,
  input  logic          in_ready,
  output logic [DW-1:0] in_data,
  input  logic          out_valid,
  output logic          out_ready,
  input  logic [DW-1:0] out_data,
  input  logic          sts_we,
  input  logic [DW-1:0] sts_data,
  input  logic          f0_set,
  input  logic          f0_clr
);
  logic          rd_fall, wr_fall, cap_a0, lock;
  logic [DW-1:0] cap_data, obuf;
  hsb_status_t   status;

  hsb_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_in(rst_in), .rst_out(sync_rst));

  hsb_host_if u_host (
    .clk(clk), .rst(sync_rst),
    .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
    .host_a0(host_a0), .host_wdata(host_wdata),
    .rd_fall(rd_fall), .wr_fall(wr_fall), .cap_a0(cap_a0),
    .cap_data(cap_data), .lock(lock)
  );

  hsb_regs u_regs (
    .clk(clk), .rst(sync_rst),
    .rd_fall(rd_fall), .wr_fall(wr_fall), .cap_a0(cap_a0),
    .cap_data(cap_data), .lock(lock),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .sts_we(sts_we), .sts_data(sts_data), .f0_set(f0_set), .f0_clr(f0_clr),
    .status(status), .obuf(obuf)
  );

  always_comb begin
    host_rdata = '0;
    if (!host_cs_n && !host_rd_n) host_rdata = host_a0 ? status : obuf;
  end
endmodule

// File: tb/hsb_bridge_test.sv
module hsb_bridge_test;
  logic       clk = 1'b0;
  logic       rst_in = 1'b1;
  logic       sync_rst;
  logic       host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_a0 = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic       in_valid, in_ready = 1'b0;
  logic [7:0] in_data;
  logic       out_valid = 1'b0, out_ready;
  logic [7:0] out_data = '0;
  logic       sts_we = 1'b0;
  logic [7:0] sts_data = '0;
  logic       f0_set = 1'b0, f0_clr = 1'b0;

  int checks = 0, errors = 0;
  logic [7:0] got;
  // Bench model of the status word.
  logic [3:0] m_user = '0;
  logic m_f1 = 0, m_f0 = 0, m_ibf = 0, m_obf = 0;

  always #2.5 clk = ~clk;

  hsb_bridge uut (.*);

  function automatic logic [7:0] m_status();
    return {m_user, m_f1, m_f0, m_ibf, m_obf};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwrite(logic cs, logic a0, logic [7:0] d);
    @(negedge clk);
    host_cs_n = ~cs; host_wr_n = 1'b0; host_a0 = a0; host_wdata = d;
    cyc(3);
    host_wr_n = 1'b1; host_cs_n = 1'b1; host_wdata = 8'hxx;
    cyc(4);
  endtask

  task automatic hread(logic a0, output logic [7:0] d);
    @(negedge clk);
    host_cs_n = 1'b0; host_rd_n = 1'b0; host_a0 = a0;
    cyc(3);
    d = host_rdata;
    host_rd_n = 1'b1; host_cs_n = 1'b1;
    cyc(4);
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk);
    d = in_data;
    in_ready = 1'b1;
    @(negedge clk);
    in_ready = 1'b0;
  endtask

  task automatic push(logic [7:0] d);
    @(negedge clk);
    out_valid = 1'b1; out_data = d;
    @(negedge clk);
    out_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(5);
    chk("R1 sync_rst high", {7'd0, sync_rst}, 8'd1);
    rst_in = 1'b0;
    cyc(1);
    chk("R1 sync_rst still high", {7'd0, sync_rst}, 8'd1);
    cyc(2);
    chk("R1 sync_rst low", {7'd0, sync_rst}, 8'd0);
    chk("R1 in_valid", {7'd0, in_valid}, 8'd0);
    chk("R1 out_ready", {7'd0, out_ready}, 8'd1);
    chk("R2 idle rdata", host_rdata, 8'h00);
    hread(1'b1, got); chk("R1 status zero", got, 8'h00);
    hread(1'b0, got); chk("R1 obuf zero", got, 8'h00);

    // Sweep all byte values through the input register.
    for (int v = 0; v < 256; v++) begin
      logic a0b;
      a0b = v[0] ^ v[3];
      hwrite(1'b1, a0b, v[7:0]);
      m_ibf = 1; m_f1 = a0b;
      chk("R4 in_valid after write", {7'd0, in_valid}, 8'd1);
      hread(1'b1, got); chk("R3 status F1/IBF", got, m_status());
      pop(got); chk("R4 in_data", got, v[7:0]);
      m_ibf = 0;
      chk("R4 ibf cleared", {7'd0, in_valid}, 8'd0);
    end

    // Sweep all byte values through the output register.
    for (int v = 0; v < 256; v++) begin
      push(v[7:0]); m_obf = 1;
      chk("R5 out_ready low when full", {7'd0, out_ready}, 8'd0);
      hread(1'b1, got); chk("R6 status read keeps OBF", got, m_status());
      hread(1'b0, got); chk("R2 data read", got, v[7:0]);
      m_obf = 0;
      chk("R6 OBF cleared", {7'd0, out_ready}, 8'd1);
    end

    // R3: no flag change while the write strobe is held.
    @(negedge clk);
    host_cs_n = 0; host_wr_n = 0; host_a0 = 0; host_wdata = 8'h3c;
    cyc(8);
    chk("R3 no IBF during strobe", {7'd0, in_valid}, 8'd0);
    host_wr_n = 1; host_cs_n = 1;
    cyc(2);
    chk("R3 no IBF two cycles after release", {7'd0, in_valid}, 8'd0);
    cyc(2);
    chk("R3 IBF after trailing edge", {7'd0, in_valid}, 8'd1);
    m_ibf = 1; m_f1 = 0;
    pop(got); m_ibf = 0; chk("R3 byte", got, 8'h3c);

    // R7: a master write leaves the output register untouched.
    push(8'ha5); m_obf = 1;
    hwrite(1'b1, 1'b1, 8'h5a); m_ibf = 1; m_f1 = 1;
    hread(1'b0, got); m_obf = 0; chk("R7 obuf kept", got, 8'ha5);
    pop(got); m_ibf = 0; chk("R7 ibuf", got, 8'h5a);

    // R8 sweep of user nibbles.
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); sts_we = 1; sts_data = {v[3:0], ~v[3:0]};
      @(negedge clk); sts_we = 0;
      m_user = v[3:0];
      hread(1'b1, got); chk("R8 user bits", got, m_status());
    end

    // R9 F0 set, clear and both.
    @(negedge clk); f0_set = 1; @(negedge clk); f0_set = 0; m_f0 = 1;
    hread(1'b1, got); chk("R9 F0 set", got, m_status());
    @(negedge clk); f0_clr = 1; @(negedge clk); f0_clr = 0; m_f0 = 0;
    hread(1'b1, got); chk("R9 F0 clear", got, m_status());
    @(negedge clk); f0_set = 1; f0_clr = 1; @(negedge clk); f0_set = 0; f0_clr = 0; m_f0 = 1;
    hread(1'b1, got); chk("R9 set wins", got, m_status());

    // R10 lockout during a status read.
    push(8'h11); m_obf = 1;
    hwrite(1'b1, 1'b0, 8'h22); m_ibf = 1; m_f1 = 0;
    @(negedge clk);
    host_cs_n = 0; host_rd_n = 0; host_a0 = 1;
    cyc(3);
    chk("R10 in_valid held low", {7'd0, in_valid}, 8'd0);
    chk("R10 status before", host_rdata, m_status());
    sts_we = 1; sts_data = 8'h90; f0_clr = 1;
    @(negedge clk); sts_we = 0; f0_clr = 0;
    sts_we = 1; sts_data = 8'h60;
    @(negedge clk); sts_we = 0;
    cyc(2);
    chk("R10 status frozen", host_rdata, m_status());
    host_rd_n = 1; host_cs_n = 1;
    cyc(4);
    m_user = 4'h6; m_f0 = 0;
    hread(1'b1, got); chk("R10 deferred applied", got, m_status());
    pop(got); m_ibf = 0; chk("R10 ibuf after lock", got, 8'h22);
    hread(1'b0, got); m_obf = 0; chk("R10 obuf after lock", got, 8'h11);

    // R11: unselected strobes.
    hwrite(1'b0, 1'b1, 8'hee);
    chk("R11 write ignored", {7'd0, in_valid}, 8'd0);
    push(8'h77); m_obf = 1;
    @(negedge clk); host_cs_n = 1; host_rd_n = 0; host_a0 = 0;
    cyc(1); chk("R11 rdata unselected", host_rdata, 8'h00);
    cyc(2); host_rd_n = 1; cyc(4);
    hread(1'b1, got); chk("R11 OBF kept", got, m_status());

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule